// File: doc/BRIEF.md
# RMII receive resynchronization bridge

This block sits between the 100 Mb/s receive decoder of a PHY and its RMII-style output. The decoder delivers one nibble per cycle of the recovered receive clock. The bridge hands that data to a 50 MHz reference clock as two-bit symbols, least significant pair first. A dual-clock elastic buffer absorbs the phase and frequency offset between the two clocks. Output is held back until a fill threshold of buffered bits has built up, so the reader never runs dry in the middle of a frame.

The combined carrier/valid output rises straight from the raw carrier input, through a combinational path. While the buffer fills, the data lines stay at zero. When the carrier goes away, the buffered data keeps draining. During that drain, carrier/valid is low on the first symbol of each nibble and high on the second, which tells the MAC that carrier has been lost while data is still arriving.

A nibble that the decoder marks as false carrier is stored as the code 1110. It leaves the block as symbols 10 then 11, with the error output raised. Carrier/valid is held high through those symbols and falls on a reference clock edge once they are gone. Buffer underflow or overflow sets a sticky error flag that only a reset clears.

Top module: `rmii_rx_bridge`

## Requirements
- R1: After the reference-domain reset, the data output is 00, the error output is 0, carrier/valid is 0 and the sticky buffer error flag is 0.
- R2: While the raw carrier input is high (and the reference-domain reset is released), carrier/valid is high in the same cycle, with no clock edge in the path.
- R3: A frame's first symbol is presented only once at least FILL_BITS bits (12 by default, so 3 nibbles) are buffered, or once carrier has been lost with fewer bits left. Until then the data output is 00.
- R4: Each buffered nibble leaves as two symbols on consecutive reference clock edges: bits [1:0] first, then bits [3:2]. The symbol stream equals the input nibble stream in order.
- R5: After carrier drops, carrier/valid is 0 during the first symbol of each drained nibble and 1 during its second. After the last buffered symbol, carrier/valid is 0 and the data output is 00.
- R6: For a frame with no false carrier, the error output stays 0 for the whole frame.
- R7: A false-carrier nibble is replaced by 1110: symbols 10 then 11, with the error output 1 during both. Carrier/valid stays 1 during those symbols and falls on the first reference clock edge after the last one.
- R8: Once a frame has fully drained, the next carrier event again waits for a full fill threshold before output starts.
- R9: If the buffer is empty at a nibble boundary while carrier is still present (underflow), or a write arrives while the buffer is full (overflow), the buffer error flag goes to 1. It stays 1 until reset.
- R10: A burst shorter than the fill threshold is still presented in full once carrier drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock (25 MHz nibble rate) |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| rx_crs | input | 1 | Raw carrier sense from the decoder |
| rx_nib_vld | input | 1 | Valid data nibble present on rx_nib |
| rx_nib | input | 4 | Received data nibble |
| rx_fc | input | 1 | Current nibble is false carrier |
| ref_clk | input | 1 | 50 MHz reference clock |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| crs_dv | output | 1 | Combined carrier-sense / data-valid |
| rxd | output | 2 | Output symbol, reference-clock synchronous |
| rx_er | output | 1 | Receive error (false carrier) |
| fifo_err | output | 1 | Sticky buffer underflow/overflow flag |

## Verification
Two things can land in the same reference cycle. The raw carrier can fall while a symbol is being output, and the end-of-frame toggle on carrier/valid must then take over from the direct carrier path at that exact symbol. The drain-complete decision can also coincide with a nibble boundary, where the sequencer must choose between loading the next entry, ending the frame and flagging underflow. The bench drops carrier in the rx cycle right after the last nibble. The reference model, which tracks carrier level and symbol parity, then judges carrier/valid on every reference cycle. The bench also stalls the nibble stream under a held carrier to force the underflow branch of that same decision.

// File: rtl/rmii_rx_pkg.sv
// Package: shared types and codes for the receive resynchronization bridge.
// Assumes nibble-wide receive data and two-bit output symbols.
package rmii_rx_pkg;

    // One buffer entry: a nibble plus its false-carrier tag.
    typedef struct packed {
        logic       fc;
        logic [3:0] nib;
    } rx_ent_t;

    // Nibble substituted for any false-carrier nibble (gives symbols 10, 11).
    localparam logic [3:0] FC_NIB = 4'hE;

endpackage

// File: rtl/rmii_rx_sync.sv
// Module: multi-stage flop synchronizer for a vector that is either Gray coded
// or made of independent single-bit levels.
// Assumes the source changes at most one bit per destination sample where
// coherence matters.
module rmii_rx_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the sampled value through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rmii_rx_mem.sv
// Module: buffer storage, written in the receive domain and read
// asynchronously from the reference domain.
// Assumes the pointer logic keeps read and write on different entries.
module rmii_rx_mem #(
    parameter int unsigned DW    = 5,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store_q [DEPTH];

    // Capture one entry per write strobe.
    always_ff @(posedge wclk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/rmii_rx_wr.sv
// Module: write-side pointer control in the recovered receive clock domain.
// Keeps binary and Gray write pointers, detects full against the synchronized
// read pointer, and holds a sticky overflow flag.
// Assumes rd_gray_s has already passed through a synchronizer.
module rmii_rx_wr #(
    parameter int unsigned AW   = 3,
    localparam int unsigned PW  = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [PW-1:0] rd_gray_s,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wr_gray,
    output logic          we,
    output logic          ovf
);

    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] wptr_nx;
    logic          full;

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        rd_bin[PW-1] = rd_gray_s[PW-1];
        for (int i = int'(PW) - 2; i >= 0; i--) rd_bin[i] = rd_bin[i+1] ^ rd_gray_s[i];
    end

    assign full    = (wptr_q - rd_bin) == DEPTH_P;
    assign we      = wr_req && !full;
    assign wptr_nx = wptr_q + PW'(1);
    assign waddr   = wptr_q[AW-1:0];

    // Advance the write pointer and record overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            wr_gray <= '0;
            ovf     <= 1'b0;
        end else begin
            if (we) begin
                wptr_q  <= wptr_nx;
                wr_gray <= wptr_nx ^ (wptr_nx >> 1);
            end
            if (wr_req && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/rmii_rx_rd.sv
// Module: reference-domain read sequencer. Waits for the fill threshold,
// splits each nibble into two symbols (low pair first), ends the frame when
// the buffer is empty after carrier loss, and flags underflow.
// Assumes wr_gray_s and crs_s are synchronized into this clock domain.
module rmii_rx_rd
    import rmii_rx_pkg::*;
#(
    parameter int unsigned AW       = 3,
    parameter int unsigned FILL_NIB = 3,
    localparam int unsigned PW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wr_gray_s,
    input  logic          crs_s,
    input  rx_ent_t       ent,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rd_gray,
    output logic [1:0]    rxd,
    output logic          er,
    output logic          emit,
    output logic          out_hi,
    output logic          und,
    output logic [PW-1:0] occ
);

    localparam logic [PW-1:0] FILL_P = PW'(FILL_NIB);

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] rptr_nx;
    logic [1:0]    hi_q;
    logic          boundary;
    logic          take;

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        wr_bin[PW-1] = wr_gray_s[PW-1];
        for (int i = int'(PW) - 2; i >= 0; i--) wr_bin[i] = wr_bin[i+1] ^ wr_gray_s[i];
    end

    assign occ      = wr_bin - rptr_q;
    assign rptr_nx  = rptr_q + PW'(1);
    assign raddr    = rptr_q[AW-1:0];
    assign boundary = !emit || out_hi;
    // Load a nibble mid-frame, or start once filled, or flush after carrier loss.
    assign take     = (occ != '0) && (emit || (occ >= FILL_P) || !crs_s);

    // Symbol sequencing, frame start/end and underflow detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            rd_gray <= '0;
            hi_q    <= 2'b00;
            rxd     <= 2'b00;
            er      <= 1'b0;
            emit    <= 1'b0;
            out_hi  <= 1'b0;
            und     <= 1'b0;
        end else if (boundary) begin
            out_hi <= 1'b0;
            if (take) begin
                rxd     <= ent.nib[1:0];
                hi_q    <= ent.nib[3:2];
                er      <= ent.fc;
                emit    <= 1'b1;
                rptr_q  <= rptr_nx;
                rd_gray <= rptr_nx ^ (rptr_nx >> 1);
            end else begin
                if (emit && crs_s) und <= 1'b1;
                rxd  <= 2'b00;
                er   <= 1'b0;
                emit <= 1'b0;
            end
        end else begin
            rxd    <= hi_q;
            out_hi <= 1'b1;
        end
    end

endmodule

// File: rtl/rmii_rx_bridge.sv
// Module: top of the receive resynchronization bridge. Connects the write
// control, storage, synchronizers and read sequencer, and forms the combined
// carrier/valid output.
// Assumes the recovered clock delivers nibbles at the same nominal bit rate
// as the reference clock delivers symbols.
module rmii_rx_bridge
    import rmii_rx_pkg::*;
#(
    parameter int unsigned FIFO_BITS = 32,
    parameter int unsigned FILL_BITS = 12,
    parameter int unsigned SYNC_STG  = 2,
    localparam int unsigned DEPTH    = FIFO_BITS / 4,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1,
    localparam int unsigned FILL_NIB = (FILL_BITS + 3) / 4
) (
    input  logic       rx_clk,
    input  logic       rx_rst_n,
    input  logic       rx_crs,
    input  logic       rx_nib_vld,
    input  logic [3:0] rx_nib,
    input  logic       rx_fc,
    input  logic       ref_clk,
    input  logic       ref_rst_n,
    output logic       crs_dv,
    output logic [1:0] rxd,
    output logic       rx_er,
    output logic       fifo_err
);

    rx_ent_t       wr_ent;
    rx_ent_t       rd_ent;
    logic          we;
    logic          ovf;
    logic          ovf_s;
    logic          crs_s;
    logic          und;
    logic          emit;
    logic          out_hi;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] wr_gray_s;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] rd_gray_s;
    logic [PW-1:0] occ;

    // Tag false carrier and substitute its fixed code.
    always_comb begin
        wr_ent.fc  = rx_fc;
        wr_ent.nib = rx_fc ? FC_NIB : rx_nib;
    end

    rmii_rx_wr #(.AW(AW)) u_wr (
        .clk       (rx_clk),
        .rst_n     (rx_rst_n),
        .wr_req    (rx_nib_vld || rx_fc),
        .rd_gray_s (rd_gray_s),
        .waddr     (waddr),
        .wr_gray   (wr_gray),
        .we        (we),
        .ovf       (ovf)
    );

    rmii_rx_mem #(.DW($bits(rx_ent_t)), .DEPTH(DEPTH)) u_mem (
        .wclk  (rx_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_ent),
        .raddr (raddr),
        .rdata (rd_ent)
    );

    rmii_rx_sync #(.W(PW), .STAGES(SYNC_STG)) u_sync_wptr (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    rmii_rx_sync #(.W(PW), .STAGES(SYNC_STG)) u_sync_rptr (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    rmii_rx_sync #(.W(2), .STAGES(SYNC_STG)) u_sync_lvl (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     ({ovf, rx_crs}),
        .q     ({ovf_s, crs_s})
    );

    rmii_rx_rd #(.AW(AW), .FILL_NIB(FILL_NIB)) u_rd (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .wr_gray_s (wr_gray_s),
        .crs_s     (crs_s),
        .ent       (rd_ent),
        .raddr     (raddr),
        .rd_gray   (rd_gray),
        .rxd       (rxd),
        .er        (rx_er),
        .emit      (emit),
        .out_hi    (out_hi),
        .und       (und),
        .occ       (occ)
    );

    // Raw carrier passes straight through; during drain the symbol phase
    // (or a false-carrier symbol) keeps carrier/valid up.
    assign crs_dv   = (rx_crs && ref_rst_n) || (emit && (out_hi || rx_er));
    assign fifo_err = und || ovf_s;

endmodule

// File: rtl/rmii_rx_bridge_chk.sv
// Module: property checker for the bridge, attached by bind in the reference
// clock domain. Observes ports and the sequencer state.
// Assumes occ and crs_s are the sequencer's view of fill level and carrier.
module rmii_rx_bridge_chk #(
    parameter int unsigned PW       = 4,
    parameter int unsigned FILL_NIB = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_crs,
    input logic          crs_dv,
    input logic [1:0]    rxd,
    input logic          rx_er,
    input logic          fifo_err,
    input logic          emit,
    input logic          out_hi,
    input logic          crs_s,
    input logic [PW-1:0] occ
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |-> (rxd == 2'b00 && !rx_er));

    p_carrier_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crs |-> crs_dv);

    p_start_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emit) |-> ($past(occ) >= PW'(FILL_NIB) || !$past(crs_s)));

    p_symbol_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !out_hi) |=> (emit && out_hi));

    p_drain_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !rx_crs && !rx_er) |-> (crs_dv == out_hi));

    p_fc_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> (crs_dv && rxd == (out_hi ? 2'b11 : 2'b10)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |=> fifo_err);

endmodule

bind rmii_rx_bridge rmii_rx_bridge_chk #(.PW(PW), .FILL_NIB(FILL_NIB)) u_chk (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .rx_crs   (rx_crs),
    .crs_dv   (crs_dv),
    .rxd      (rxd),
    .rx_er    (rx_er),
    .fifo_err (fifo_err),
    .emit     (emit),
    .out_hi   (out_hi),
    .crs_s    (crs_s),
    .occ      (occ)
);

// File: tb/rmii_rx_bridge_tb_top.sv
// Bench: drives nibble frames on a 25 MHz recovered clock. A behavioural
// queue model compares every 50 MHz reference cycle.
module rmii_rx_bridge_tb_top;

    localparam int FILL = 3;

    logic       ref_clk = 1'b0;
    logic       rx_clk  = 1'b0;
    logic       ref_rst_n = 1'b0;
    logic       rx_rst_n  = 1'b0;
    logic       rx_crs = 1'b0;
    logic       rx_nib_vld = 1'b0;
    logic [3:0] rx_nib = 4'h0;
    logic       rx_fc = 1'b0;
    logic       crs_dv;
    logic [1:0] rxd;
    logic       rx_er;
    logic       fifo_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wr_cnt = 0;
    int idx = 0;
    bit mon_en = 1'b0;
    bit started = 1'b0;
    logic [2:0] expq[$];

    rmii_rx_bridge dut_i (
        .rx_clk     (rx_clk),
        .rx_rst_n   (rx_rst_n),
        .rx_crs     (rx_crs),
        .rx_nib_vld (rx_nib_vld),
        .rx_nib     (rx_nib),
        .rx_fc      (rx_fc),
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .crs_dv     (crs_dv),
        .rxd        (rxd),
        .rx_er      (rx_er),
        .fifo_err   (fifo_err)
    );

    always #10 ref_clk = ~ref_clk;
    initial begin
        #5;
        forever #20 rx_clk = ~rx_clk;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge ref_clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 0);
            finish_run();
        end
    end

    // Count nibbles actually accepted in the current frame.
    always @(posedge rx_clk) if (rx_nib_vld || rx_fc) wr_cnt++;

    // Reference model, evaluated away from the active edge.
    always @(negedge ref_clk) begin
        if (mon_en) begin
            if (started && expq.size() == 0) started = 1'b0;
            if (!started && expq.size() > 0 && (rxd != 2'b00 || rx_er)) begin
                started = 1'b1;
                idx = 0;
                check(wr_cnt >= FILL || !rx_crs, "R3 start before fill", wr_cnt, FILL);
            end
            if (started) begin
                logic [2:0] e;
                logic       exp_dv;
                e = expq.pop_front();
                exp_dv = rx_crs || e[2] || idx[0];
                check(rxd == e[1:0], e[2] ? "R7 symbol" : "R4 symbol", rxd, e[1:0]);
                check(rx_er == e[2], e[2] ? "R7 error" : "R6 error", rx_er, e[2]);
                check(crs_dv == exp_dv, rx_crs ? "R2 crs_dv" : (e[2] ? "R7 crs_dv" : "R5 crs_dv"),
                      crs_dv, exp_dv);
                idx++;
            end else begin
                check(rxd == 2'b00 && !rx_er, "R3 idle/fill output", {rx_er, rxd}, 0);
                check(crs_dv == rx_crs, rx_crs ? "R2 crs_dv" : "R5 crs_dv after drain", crs_dv, rx_crs);
                check(fifo_err == 1'b0, "R9 no spurious error", fifo_err, 0);
            end
        end
    end

    // Send one frame: n nibbles, false carrier or data with a preamble head.
    task automatic send(input int n, input bit fc, input int pat);
        @(negedge rx_clk);
        wr_cnt = 0;
        rx_crs = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [3:0] nb;
            if (fc) nb = 4'hE;
            else if (i < 7) nb = 4'h5;
            else if (i == 7) nb = 4'hD;
            else nb = 4'((pat + i * 3) & 15);
            rx_nib     = fc ? 4'h0 : nb;
            rx_nib_vld = !fc;
            rx_fc      = fc;
            expq.push_back({fc, nb[1:0]});
            expq.push_back({fc, nb[3:2]});
            @(negedge rx_clk);
        end
        rx_crs     = 1'b0;
        rx_nib_vld = 1'b0;
        rx_fc      = 1'b0;
    endtask

    task automatic wait_drain();
        int t = 0;
        while ((expq.size() != 0 || started) && t < 2000) begin
            @(negedge ref_clk);
            t++;
        end
        check(expq.size() == 0, "R8 frame fully drained", expq.size(), 0);
        repeat (6) @(negedge ref_clk);
    endtask

    task automatic do_reset();
        ref_rst_n = 1'b0;
        rx_rst_n  = 1'b0;
        repeat (6) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        rx_rst_n  = 1'b1;
        @(negedge ref_clk);
    endtask

    initial begin
        do_reset();
        // R1: reset state.
        check(rxd == 2'b00, "R1 rxd after reset", rxd, 0);
        check(rx_er == 1'b0, "R1 rx_er after reset", rx_er, 0);
        check(crs_dv == 1'b0, "R1 crs_dv after reset", crs_dv, 0);
        check(fifo_err == 1'b0, "R1 fifo_err after reset", fifo_err, 0);
        mon_en = 1'b1;

        send(20, 1'b0, 1);      // R4 R5 R6: ordinary frame
        wait_drain();
        send(14, 1'b0, 7);      // R8: fresh fill after drain
        wait_drain();
        send(5, 1'b1, 0);       // R7: false carrier
        wait_drain();
        send(2, 1'b1, 0);       // R10: burst below threshold, flushed
        wait_drain();
        send(9, 1'b0, 11);      // R3 R8: short data frame after a burst
        wait_drain();

        // R9: underflow, carrier held with no data.
        mon_en = 1'b0;
        @(negedge rx_clk);
        rx_crs = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rx_nib = 4'h5;
            rx_nib_vld = 1'b1;
            @(negedge rx_clk);
        end
        rx_nib_vld = 1'b0;
        repeat (10) @(negedge rx_clk);
        rx_crs = 1'b0;
        repeat (20) @(negedge ref_clk);
        check(fifo_err == 1'b1, "R9 underflow flagged", fifo_err, 1);
        repeat (20) @(negedge ref_clk);
        check(fifo_err == 1'b1, "R9 flag sticky", fifo_err, 1);
        do_reset();
        check(fifo_err == 1'b0, "R9 cleared by reset", fifo_err, 0);
        check(rxd == 2'b00 && crs_dv == 1'b0, "R1 outputs after second reset", {crs_dv, rxd}, 0);
        expq.delete();
        started = 1'b0;
        mon_en = 1'b1;
        send(12, 1'b0, 3);      // normal operation again
        wait_drain();
        finish_run();
    end

endmodule